// File: doc/BRIEF.md
# Masked Block-Write Video Memory

This block is a clocked model of a video memory array sixteen bits wide that offers a block-write path next to ordinary word access. Each row holds 512 columns. Eight neighbouring columns make up one aligned block, so a row has 64 blocks. A single block-write cycle copies a preloaded 16-bit color word into any subset of a block's columns. Three gates decide which bits change, and a bit is written only if all three allow it:

- a column mask that arrives on the data bus in the same cycle;
- a per-bit write mask held in a register;
- the lower and upper byte enables.

Strobe edges are modelled as one-cycle commands. Every command is sampled on a rising clock edge while `cmd_valid` is high. Commands are:

- a normal write, which is a write with `blk_sel` low;
- a block write, which is a write with `blk_sel` high;
- a load of the color register;
- a load of the write mask;
- a read, whose word comes back one cycle later.

The data bus is both the write data and the column-mask source. That makes it the same-cycle equivalent of taking the mask at the later of the two strobe events.

Top module: `vram_blkwr_top`

## Requirements
- R1: After synchronous reset, `rd_valid` is 0, the color register is 0 and the write mask is all ones (16'hFFFF).
- R2: A read command (`cmd_op`=2'd1) makes `rd_valid` high for exactly the following cycle, and `rd_data` then holds the word stored at {row, column}.
- R3: A write command (`cmd_op`=2'd0) with `blk_sel`=0 stores `dq_in` into the addressed word. The lower byte is stored only if `be_lo`=1 and the upper byte only if `be_hi`=1. The write mask does not apply.
- R4: Command 2'd2 loads `dq_in` into the color register and command 2'd3 loads it into the write mask. Neither load changes any array word.
- R5: In a block write, only `col_addr[8:3]` selects the block. `col_addr[2:0]` has no effect.
- R6: In a block write, column-mask bit `dq_in[4q+k]` enables the bits [4q+3:4q] of column 8*block + 4*(q mod 2) + k, for q in 0..3 and k in 0..3. A column whose mask bit is 0 keeps those four bits.
- R7: In a block write, a bit position whose write-mask bit is 0 keeps its previous value in every column.
- R8: In a block write, `be_lo`=0 protects bits 7:0 and `be_hi`=0 protects bits 15:8 of every column.
- R9: Every bit a block write changes takes its value from the color register, never from `dq_in`.
- R10: While `cmd_valid` is 0, no array word, register or read output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 write, 1 read, 2 load color, 3 load write mask |
| blk_sel | input | 1 | Turns a write into a block write |
| row_addr | input | ROW_W | Row address |
| col_addr | input | 9 | Column address (bits 8:3 pick the block) |
| dq_in | input | 16 | Write data, or column mask during a block write |
| be_lo | input | 1 | Enables bits 7:0 |
| be_hi | input | 1 | Enables bits 15:8 |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |

## Verification
Write, block-write and load commands take effect at the rising edge on which they are sampled. Their results can only be seen through a later read. A read's word and its `rd_valid` pulse appear after exactly one register stage. The bench drives every command at a falling edge and leaves it for one rising edge. It samples `rd_data` and `rd_valid` at the next falling edge, which is the only cycle in which the read result is defined. The bench compares those values with a reference array. It updates that array from the requirements at the moment it issues each command.

// File: rtl/vbw_pkg.sv
package vbw_pkg;
    localparam int DQ_W     = 16;
    localparam int QUAD_W   = 4;
    localparam int QUADS    = DQ_W / QUAD_W;
    localparam int COL_W    = 9;
    localparam int BLK_COLS = 8;
    localparam int SUB_W    = $clog2(BLK_COLS);
    localparam int BLK_W    = COL_W - SUB_W;

    typedef enum logic [1:0] {
        OP_WRITE   = 2'd0,
        OP_READ    = 2'd1,
        OP_LDCOLOR = 2'd2,
        OP_LDWMASK = 2'd3
    } op_e;

    typedef struct packed {
        logic wr;
        logic blk;
        logic rd;
        logic ld_color;
        logic ld_wmask;
    } dec_t;

    function automatic dec_t decode_cmd(logic valid, op_e op, logic sel);
        dec_t d;
        d.wr       = valid && (op == OP_WRITE) && !sel;
        d.blk      = valid && (op == OP_WRITE) && sel;
        d.rd       = valid && (op == OP_READ);
        d.ld_color = valid && (op == OP_LDCOLOR);
        d.ld_wmask = valid && (op == OP_LDWMASK);
        return d;
    endfunction

    function automatic logic [DQ_W-1:0] byte_gate(logic lo, logic hi);
        return {{(DQ_W/2){hi}}, {(DQ_W/2){lo}}};
    endfunction
endpackage

// File: rtl/vbw_regs.sv
module vbw_regs
    import vbw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_color,
    input  logic            ld_wmask,
    input  logic [DQ_W-1:0] dq_in,
    output logic [DQ_W-1:0] color,
    output logic [DQ_W-1:0] wmask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            color <= '0;
            wmask <= '1;
        end else begin
            if (ld_color) color <= dq_in;
            if (ld_wmask) wmask <= dq_in;
        end
    end

    assert_color_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !ld_color |=> $stable(color));
    assert_wmask_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !ld_wmask |=> $stable(wmask));
endmodule

// File: rtl/vbw_lane_mask.sv
module vbw_lane_mask
    import vbw_pkg::*;
(
    input  logic [DQ_W-1:0]                cmask,
    input  logic [DQ_W-1:0]                wmask,
    input  logic [DQ_W-1:0]                gate,
    output logic [BLK_COLS-1:0][DQ_W-1:0]  col_en
);
    logic [BLK_COLS-1:0][DQ_W-1:0] raw;

    // Quad q covers the half of the block picked by its low index bit (R6).
    for (genvar j = 0; j < BLK_COLS; j++) begin : g_col
        for (genvar q = 0; q < QUADS; q++) begin : g_quad
            if ((q % 2) == (j / QUAD_W)) begin : g_on
                assign raw[j][QUAD_W*q +: QUAD_W] = {QUAD_W{cmask[QUAD_W*q + (j % QUAD_W)]}};
            end else begin : g_off
                assign raw[j][QUAD_W*q +: QUAD_W] = '0;
            end
        end
        assign col_en[j] = raw[j] & wmask & gate;
    end
endmodule

// File: rtl/vbw_array.sv
module vbw_array
    import vbw_pkg::*;
#(
    parameter int ROWS  = 4,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int DEPTH = ROWS << COL_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic                          blk_en,
    input  logic                          rd_en,
    input  logic [ROW_W-1:0]              row,
    input  logic [COL_W-1:0]              col,
    input  logic [DQ_W-1:0]               dq_in,
    input  logic [DQ_W-1:0]               gate,
    input  logic [DQ_W-1:0]               color,
    input  logic [BLK_COLS-1:0][DQ_W-1:0] col_en,
    output logic                          rd_valid,
    output logic [DQ_W-1:0]               rd_data
);
    logic [DQ_W-1:0] mem [DEPTH];
    logic [ROW_W+COL_W-1:0] word_idx;

    assign word_idx = {row, col};

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[word_idx] <= (mem[word_idx] & ~gate) | (dq_in & gate);
        end
        if (blk_en) begin
            for (int j = 0; j < BLK_COLS; j++) begin
                mem[{row, col[COL_W-1:SUB_W], SUB_W'(j)}] <=
                    (mem[{row, col[COL_W-1:SUB_W], SUB_W'(j)}] & ~col_en[j]) | (color & col_en[j]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= mem[word_idx];
        end
    end

    assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    assert_rd_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);
    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
    assert_byte_guard_R8: assert property (@(posedge clk) disable iff (rst)
        (blk_en && gate[DQ_W-1:DQ_W/2] == '0) |-> ((col_en & {BLK_COLS{16'h00FF}}) == col_en));
endmodule

// File: rtl/vram_blkwr_top.sv
module vram_blkwr_top
    import vbw_pkg::*;
#(
    parameter int ROWS  = 4,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             blk_sel,
    input  logic [ROW_W-1:0] row_addr,
    input  logic [8:0]       col_addr,
    input  logic [15:0]      dq_in,
    input  logic             be_lo,
    input  logic             be_hi,
    output logic             rd_valid,
    output logic [15:0]      rd_data
);
    dec_t                          dec;
    logic [DQ_W-1:0]               color;
    logic [DQ_W-1:0]               wmask;
    logic [DQ_W-1:0]               gate;
    logic [BLK_COLS-1:0][DQ_W-1:0] col_en;

    assign dec  = decode_cmd(cmd_valid, op_e'(cmd_op), blk_sel);
    assign gate = byte_gate(be_lo, be_hi);

    vbw_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .ld_color (dec.ld_color),
        .ld_wmask (dec.ld_wmask),
        .dq_in    (dq_in),
        .color    (color),
        .wmask    (wmask)
    );

    vbw_lane_mask u_lanes (
        .cmask  (dq_in),
        .wmask  (wmask),
        .gate   (gate),
        .col_en (col_en)
    );

    vbw_array #(.ROWS(ROWS)) u_array (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (dec.wr),
        .blk_en   (dec.blk),
        .rd_en    (dec.rd),
        .row      (row_addr),
        .col      (col_addr),
        .dq_in    (dq_in),
        .gate     (gate),
        .color    (color),
        .col_en   (col_en),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: tb/sim_vram_blkwr_top.sv
module sim_vram_blkwr_top;
    localparam int ROWS  = 4;
    localparam int ROW_W = 2;
    localparam int DEPTH = ROWS * 512;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = 2'd0;
    logic             blk_sel = 1'b0;
    logic [ROW_W-1:0] row_addr = '0;
    logic [8:0]       col_addr = '0;
    logic [15:0]      dq_in = '0;
    logic             be_lo = 1'b0;
    logic             be_hi = 1'b0;
    logic             rd_valid;
    logic [15:0]      rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [15:0] ref_mem [DEPTH];
    logic [15:0] ref_color = 16'h0000;
    logic [15:0] ref_wmask = 16'hFFFF;

    always #4 clk = ~clk;

    vram_blkwr_top #(.ROWS(ROWS)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .blk_sel(blk_sel),
        .row_addr(row_addr), .col_addr(col_addr), .dq_in(dq_in), .be_lo(be_lo), .be_hi(be_hi),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic int idx(input logic [ROW_W-1:0] r, input logic [8:0] c);
        return int'(r) * 512 + int'(c);
    endfunction

    function automatic logic [15:0] bytes_of(input logic lo, input logic hi);
        return {{8{hi}}, {8{lo}}};
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic sel, input logic [ROW_W-1:0] r,
                         input logic [8:0] c, input logic [15:0] d, input logic lo, input logic hi);
        cmd_valid = 1'b1; cmd_op = op; blk_sel = sel; row_addr = r; col_addr = c;
        dq_in = d; be_lo = lo; be_hi = hi;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic nwrite(input logic [ROW_W-1:0] r, input logic [8:0] c, input logic [15:0] d,
                          input logic lo, input logic hi);
        logic [15:0] g;
        g = bytes_of(lo, hi);
        issue(2'd0, 1'b0, r, c, d, lo, hi);
        ref_mem[idx(r, c)] = (ref_mem[idx(r, c)] & ~g) | (d & g);
    endtask

    task automatic bwrite(input logic [ROW_W-1:0] r, input logic [8:0] c, input logic [15:0] cm,
                          input logic lo, input logic hi);
        logic [15:0] g;
        logic [15:0] m;
        logic [8:0]  colx;
        g = bytes_of(lo, hi);
        issue(2'd0, 1'b1, r, c, cm, lo, hi);
        for (int j = 0; j < 8; j++) begin
            m = '0;
            for (int q = 0; q < 4; q++)
                if ((q % 2) == (j / 4) && cm[4*q + (j % 4)]) m[4*q +: 4] = 4'hF;
            m = m & ref_wmask & g;
            colx = {c[8:3], 3'(j)};
            ref_mem[idx(r, colx)] = (ref_mem[idx(r, colx)] & ~m) | (ref_color & m);
        end
    endtask

    task automatic ld_color(input logic [15:0] d);
        issue(2'd2, 1'b0, '0, '0, d, 1'b1, 1'b1);
        ref_color = d;
    endtask

    task automatic ld_wmask(input logic [15:0] d);
        issue(2'd3, 1'b0, '0, '0, d, 1'b1, 1'b1);
        ref_wmask = d;
    endtask

    task automatic rd_check(input string tag, input logic [ROW_W-1:0] r, input logic [8:0] c);
        issue(2'd1, 1'b0, r, c, 16'h0, 1'b0, 1'b0);
        check({tag, " R2 valid"}, {15'd0, rd_valid}, 16'd1);
        check(tag, rd_data, ref_mem[idx(r, c)]);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] tmp;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 rd_valid after reset", {15'd0, rd_valid}, 16'd0);
        check("R1 rd_data after reset", rd_data, 16'd0);

        // Fill the array with known words (R3 full-byte writes)
        for (int a = 0; a < DEPTH; a++)
            nwrite(ROW_W'(a / 512), 9'(a % 512), 16'(($urandom() & 16'hFFFF)), 1'b1, 1'b1);

        // R1: color resets to 0 and write mask to all ones
        bwrite(2'd0, 9'd0, 16'hFFFF, 1'b1, 1'b1);
        for (int j = 0; j < 8; j++) rd_check("R1 reset color/wmask", 2'd0, 9'(j));

        // R2: valid pulse lasts one cycle
        @(negedge clk);
        check("R2 rd_valid drops", {15'd0, rd_valid}, 16'd0);

        // R3: byte enables on normal writes, write mask ignored
        ld_wmask(16'h0000);
        nwrite(2'd1, 9'd20, 16'hA5C3, 1'b1, 1'b0);
        rd_check("R3 lower byte only", 2'd1, 9'd20);
        nwrite(2'd1, 9'd21, 16'h3C5A, 1'b0, 1'b1);
        rd_check("R3 upper byte only", 2'd1, 9'd21);
        ld_wmask(16'hFFFF);

        // R4: loads leave the array alone
        ld_color(16'hBEEF);
        rd_check("R4 array after load color", 2'd1, 9'd20);
        ld_wmask(16'hFFFF);
        rd_check("R4 array after load wmask", 2'd1, 9'd21);

        // R5: low column bits ignored in block write
        ld_color(16'h1357);
        bwrite(2'd2, 9'b000101_101, 16'hFFFF, 1'b1, 1'b1);
        for (int j = 0; j < 8; j++) rd_check("R5 block select", 2'd2, {6'b000101, 3'(j)});
        rd_check("R5 neighbour block", 2'd2, 9'b000110_000);

        // R6: single column-mask bit 6 -> quad 1, column 4+2
        ld_color(16'hFFFF);
        nwrite(2'd3, 9'd80, 16'h0000, 1'b1, 1'b1);
        nwrite(2'd3, 9'd86, 16'h0000, 1'b1, 1'b1);
        bwrite(2'd3, 9'd80, 16'h0040, 1'b1, 1'b1);
        rd_check("R6 selected column", 2'd3, 9'd86);
        rd_check("R6 unselected column", 2'd3, 9'd80);
        check("R6 exact quad", ref_mem[idx(2'd3, 9'd86)], 16'h00F0);

        // R7: write mask bits
        ld_color(16'h0F0F);
        ld_wmask(16'h5A5A);
        bwrite(2'd0, 9'd64, 16'hA3C5, 1'b1, 1'b1);
        for (int j = 0; j < 8; j++) rd_check("R7 write mask", 2'd0, 9'(64 + j));
        ld_wmask(16'hFFFF);

        // R8: byte enables in block write
        ld_color(16'hC33C);
        bwrite(2'd1, 9'd128, 16'hFFFF, 1'b0, 1'b1);
        for (int j = 0; j < 8; j++) rd_check("R8 upper only", 2'd1, 9'(128 + j));
        bwrite(2'd1, 9'd136, 16'hFFFF, 1'b1, 1'b0);
        for (int j = 0; j < 8; j++) rd_check("R8 lower only", 2'd1, 9'(136 + j));

        // R9: data from color register, not bus
        ld_color(16'h9669);
        bwrite(2'd2, 9'd200, 16'hFFFF, 1'b1, 1'b1);
        rd_check("R9 color source", 2'd2, 9'd200);

        // R10: cmd_valid low does nothing
        tmp = ref_mem[idx(2'd2, 9'd200)];
        cmd_op = 2'd0; blk_sel = 1'b0; row_addr = 2'd2; col_addr = 9'd200;
        dq_in = ~tmp; be_lo = 1'b1; be_hi = 1'b1;
        @(negedge clk);
        cmd_op = 2'd2;
        @(negedge clk);
        check("R10 rd_valid idle", {15'd0, rd_valid}, 16'd0);
        rd_check("R10 array unchanged", 2'd2, 9'd200);
        bwrite(2'd2, 9'd200, 16'hFFFF, 1'b1, 1'b1);
        rd_check("R10 color unchanged", 2'd2, 9'd200);

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            int k;
            logic [ROW_W-1:0] r;
            logic [8:0] c;
            k = int'($urandom() % 10);
            r = ROW_W'($urandom());
            c = 9'($urandom());
            case (k)
                0, 1:    nwrite(r, c, 16'($urandom()), 1'($urandom()), 1'($urandom()));
                2, 3, 4: bwrite(r, c, 16'($urandom()), 1'($urandom()), 1'($urandom()));
                5:       ld_color(16'($urandom()));
                6:       ld_wmask(16'($urandom()));
                default: rd_check("R6 random read", r, c);
            endcase
        end

        // Final sweep of every word
        for (int a = 0; a < DEPTH; a++)
            rd_check("R6 sweep", ROW_W'(a / 512), 9'(a % 512));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule